// File: doc/BRIEF.md
# Octet Slot Buffer with Slip Control

This block sits between a 64 kbit/s codirectional decoder and a 2.048 Mbit/s PCM highway. Whole octets arrive from the decoder, each tagged with whether its closing octet-timing violation was seen. The block parks each octet in one of two 8-bit holding registers. It then sends the octet onto the highway as a burst of eight serial bits inside a locally timed time-slot envelope. One register is read during a burst while the other accepts the next octet, so arrivals never disturb a burst in progress.

The arrival rate and the highway rate are not locked, so the block slips whole octets. If two or more octets arrive between two burst starts, only the newest is sent and the delete flag marks the burst that carries it. If no octet arrived, the previous octet is sent again and the insert flag marks that burst. The output can be forced to all ones on request. It can also be forced to all ones when supervision is enabled and the octet being sent came without its timing violation.

Octet arrival is an arrival strobe qualified in the same clock domain as the highway; the recovered-rate timing is reduced to that strobe upstream. The arrival side has no back-pressure: an octet offered with `oct_valid` high is always taken in that cycle, and a surplus is resolved by deletion, never by stalling the source.

Top module: `octet_slot_buffer`

## Requirements
- R1: During and right after reset, `pcm_out` is 1, `ins_flag` is 0 and `del_flag` is 0, and both holding registers contain all ones.
- R2: With `ts_sel` = 1 the strobe `ts_a` frames bursts and `ts_b` is ignored; with `ts_sel` = 0 `ts_b` is used and `ts_a` is ignored. A pulse on the unselected strobe leaves `pcm_out` at 1, leaves the flags at 0 and consumes no octet.
- R3: A burst starts at the first clock edge where the selected strobe is high after having been low. Bit 0 (LSB) appears on `pcm_out` after that edge, and bits 1 to 7 follow on the next seven edges while the strobe stays high. `pcm_out` is 1 at every other time, including after the strobe falls.
- R4: An octet that arrives during a burst does not change the bits of that burst. It is sent in the next burst.
- R5: If two or more octets arrive between consecutive burst starts, the next burst sends the last of them and the earlier ones are dropped. `del_flag` is 1 for all eight bit cycles of that burst.
- R6: If no octet arrived since the previous burst start, the burst repeats the previously sent octet, which is all ones before the first arrival. `ins_flag` is 1 for all eight bit cycles of that burst.
- R7: While `blank_force` is 1, the burst bits are all 1. The octet due for that burst is still consumed, so a following burst with no new arrival repeats it unblanked.
- R8: While `sup_n` is 0, an octet that arrived with `oct_viol` = 0 is sent as all ones. An octet with `oct_viol` = 1, or any octet while `sup_n` is 1, is sent unchanged.
- R9: `ins_flag` and `del_flag` are 0 outside the eight bit cycles of a burst, and they are never 1 together.
- R10: An octet that arrives in the same cycle as a burst start is held for the next burst. That burst sends the octet that was pending before, or repeats the previous octet, and the arrival counts as no deletion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oct_valid | input | 1 | Octet arrival strobe, one cycle per octet |
| oct_data | input | 8 | Arriving octet, bit 0 sent first |
| oct_viol | input | 1 | 1 when the octet closed with its timing violation |
| ts_sel | input | 1 | Strobe select: 1 uses `ts_a`, 0 uses `ts_b` |
| ts_a | input | 1 | Time-slot envelope A |
| ts_b | input | 1 | Time-slot envelope B |
| sup_n | input | 1 | Active-low supervision enable for violation-based blanking |
| blank_force | input | 1 | Forces all-ones bursts while high |
| pcm_out | output | 1 | Serial highway data, idles at 1 |
| ins_flag | output | 1 | High during a burst that repeats an octet |
| del_flag | output | 1 | High during the burst that follows a dropped octet |

## Verification
The hardest cases to reach are the ordering collisions: an arrival in the very cycle a burst starts, and an arrival in the middle of a burst while the other register still holds an unsent octet. Directed bursts place the arrival strobe on the same edge as the strobe rise and on the third bit cycle. Randomized rounds then vary the number of arrivals per slot from zero to two, the strobe choice, supervision, violation tags and forced blanking, so repeats and deletions happen back to back.

// File: rtl/osb_pkg.sv
package osb_pkg;
  // Slip status latched at the start of a burst.
  typedef struct packed {
    logic rep;   // burst repeats the previous octet
    logic del;   // one or more octets were dropped before this burst
  } slip_t;
endpackage

// File: rtl/osb_strobe_sel.sv
module osb_strobe_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic ts_sel,
  input  logic ts_a,
  input  logic ts_b,
  output logic ts_on,
  output logic start
);
  logic ts_prev;

  assign ts_on = ts_sel ? ts_a : ts_b;
  // Previous value resets high so a strobe already high at reset release
  // never yields a partial burst.
  assign start = ts_on & ~ts_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_prev <= 1'b1;
    else        ts_prev <= ts_on;
  end
endmodule

// File: rtl/osb_octet_bank.sv
module osb_octet_bank
  import osb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_viol,
  input  logic              start,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_viol,
  output slip_t             slip
);
  localparam int NSLOT = 2;

  logic rd_idx;     // register currently owned by the reader
  logic rd_next;
  logic wr_idx;
  logic pend;       // the non-read register holds an unsent octet
  logic del_pend;   // an unsent octet was overwritten since the last start

  // At a start the reader takes the pending register; otherwise it stays.
  assign rd_next = (start && pend) ? ~rd_idx : rd_idx;
  // The writer always targets the register the reader does not own next.
  assign wr_idx  = ~rd_next;

  assign slip.rep = ~pend;
  assign slip.del = del_pend;

  logic [DATA_W-1:0] slot_q [NSLOT];
  logic              slot_v [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [DATA_W-1:0] q;
    logic              v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '1;
        v <= 1'b0;
      end else if (wr_valid && (wr_idx == 1'(g))) begin
        q <= wr_data;
        v <= wr_viol;
      end
    end
    assign slot_q[g] = q;
    assign slot_v[g] = v;
  end

  assign rd_word = slot_q[rd_next];
  assign rd_viol = slot_v[rd_next];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx   <= 1'b0;
      pend     <= 1'b0;
      del_pend <= 1'b0;
    end else begin
      rd_idx <= rd_next;
      pend   <= (pend & ~start) | wr_valid;
      if (start)                  del_pend <= 1'b0;
      else if (wr_valid && pend)  del_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/osb_burst_shift.sv
module osb_burst_shift
  import osb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ts_on,
  input  logic [DATA_W-1:0] word,
  input  logic              viol,
  input  slip_t             slip,
  input  logic              blank_force,
  input  logic              sup_n,
  output logic              pcm_out,
  output logic              ins_flag,
  output logic              del_flag
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);

  logic [CNT_W-1:0] cnt;    // next bit index while a burst runs, 0 when idle
  logic [IDX_W-1:0] idx;
  logic             mask;
  logic             bit_v;
  logic             more;

  assign mask  = blank_force | (~sup_n & ~viol);
  assign idx   = start ? '0 : cnt[IDX_W-1:0];
  assign bit_v = mask | word[idx];
  assign more  = ts_on && (cnt != '0) && (cnt < CNT_W'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pcm_out  <= 1'b1;
      ins_flag <= 1'b0;
      del_flag <= 1'b0;
    end else if (start) begin
      cnt      <= CNT_W'(1);
      pcm_out  <= bit_v;
      ins_flag <= slip.rep;
      del_flag <= slip.del;
    end else if (more) begin
      cnt      <= cnt + CNT_W'(1);
      pcm_out  <= bit_v;
    end else begin
      cnt      <= '0;
      pcm_out  <= 1'b1;
      ins_flag <= 1'b0;
      del_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/octet_slot_buffer.sv
module octet_slot_buffer
  import osb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oct_valid,
  input  logic [DATA_W-1:0] oct_data,
  input  logic              oct_viol,
  input  logic              ts_sel,
  input  logic              ts_a,
  input  logic              ts_b,
  input  logic              sup_n,
  input  logic              blank_force,
  output logic              pcm_out,
  output logic              ins_flag,
  output logic              del_flag
);
  logic              ts_on;
  logic              start;
  logic [DATA_W-1:0] rd_word;
  logic              rd_viol;
  slip_t             slip;

  osb_strobe_sel u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .ts_sel (ts_sel),
    .ts_a   (ts_a),
    .ts_b   (ts_b),
    .ts_on  (ts_on),
    .start  (start)
  );

  osb_octet_bank #(.DATA_W(DATA_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (oct_valid),
    .wr_data  (oct_data),
    .wr_viol  (oct_viol),
    .start    (start),
    .rd_word  (rd_word),
    .rd_viol  (rd_viol),
    .slip     (slip)
  );

  osb_burst_shift #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ts_on       (ts_on),
    .word        (rd_word),
    .viol        (rd_viol),
    .slip        (slip),
    .blank_force (blank_force),
    .sup_n       (sup_n),
    .pcm_out     (pcm_out),
    .ins_flag    (ins_flag),
    .del_flag    (del_flag)
  );
endmodule

// File: rtl/osb_checker.sv
module osb_checker #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic ts_sel,
  input logic ts_a,
  input logic ts_b,
  input logic blank_force,
  input logic pcm_out,
  input logic ins_flag,
  input logic del_flag
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic             strobe;
  logic             strobe_q;
  logic [CNT_W-1:0] win;   // bit cycles of the current burst window

  assign strobe = ts_sel ? ts_a : ts_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      win      <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe && !strobe_q)
        win <= CNT_W'(1);
      else if (strobe && win != '0 && win < CNT_W'(DATA_W))
        win <= win + CNT_W'(1);
      else
        win <= '0;
    end
  end

  // R3: selected strobe low at an edge leaves the line idle after it
  a_r3_idle_outside_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (pcm_out && !ins_flag && !del_flag));

  // R7: forced blanking yields ones
  a_r7_blank_ones: assert property (@(posedge clk) disable iff (!rst_n)
    blank_force |=> pcm_out);

  // R9: slip flags never together
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_flag && del_flag));

  // R9: slip flags only inside a burst window
  a_r9_flags_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_flag || del_flag) |-> (win != '0));

  // R5 / R6: a flag raised at a burst start stays for the whole window
  a_r6_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((ins_flag || del_flag) && strobe && win != '0 && win < CNT_W'(DATA_W))
      |=> (ins_flag || del_flag));
endmodule

bind octet_slot_buffer osb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ts_sel      (ts_sel),
  .ts_a        (ts_a),
  .ts_b        (ts_b),
  .blank_force (blank_force),
  .pcm_out     (pcm_out),
  .ins_flag    (ins_flag),
  .del_flag    (del_flag)
);

// File: tb/octet_slot_buffer_tb.sv
module octet_slot_buffer_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oct_valid = 1'b0;
  logic [W-1:0] oct_data = '0;
  logic oct_viol = 1'b0;
  logic ts_sel = 1'b1, ts_a = 1'b0, ts_b = 1'b0;
  logic sup_n = 1'b1, blank_force = 1'b0;
  logic pcm_out, ins_flag, del_flag;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit         m_pend = 0;
  logic [W-1:0] m_pd = '1;
  bit         m_pv = 0;
  logic [W-1:0] m_cur = '1;
  bit         m_cv = 0;
  bit         m_del = 0;

  always #2 clk = ~clk;   // 250 MHz

  octet_slot_buffer #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .oct_valid(oct_valid), .oct_data(oct_data),
    .oct_viol(oct_viol), .ts_sel(ts_sel), .ts_a(ts_a), .ts_b(ts_b),
    .sup_n(sup_n), .blank_force(blank_force),
    .pcm_out(pcm_out), .ins_flag(ins_flag), .del_flag(del_flag)
  );

  task automatic chk(input bit ok, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", what, got, exp);
    end
  endtask

  // model: an octet arrival
  function automatic void m_arrive(input logic [W-1:0] d, input bit v);
    if (m_pend) m_del = 1;
    m_pd = d; m_pv = v; m_pend = 1;
  endfunction

  task automatic send(input logic [W-1:0] d, input bit v);
    @(negedge clk);
    oct_valid = 1; oct_data = d; oct_viol = v;
    @(negedge clk);
    oct_valid = 0;
    m_arrive(d, v);
  endtask

  task automatic set_strobe(input bit sel, input bit val);
    if (sel) ts_a = val; else ts_b = val;
  endtask

  // One burst; optional arrival on the start edge or on the third bit cycle.
  task automatic burst(input bit sel, input bit blk, input bit sup,
                       input bit st_wr, input logic [W-1:0] st_d, input bit st_v,
                       input bit md_wr, input logic [W-1:0] md_d, input bit md_v,
                       input string tag);
    logic [W-1:0] e_word, got;
    bit e_ins, e_del, flag_ok;
    @(negedge clk);
    ts_sel = sel; blank_force = blk; sup_n = sup;
    // expectation from state before the start edge
    if (m_pend) begin
      m_cur = m_pd; m_cv = m_pv; e_ins = 0; e_del = m_del; m_pend = 0;
    end else begin
      e_ins = 1; e_del = 0;
    end
    m_del = 0;
    e_word = (blk || (!sup && !m_cv)) ? '1 : m_cur;
    set_strobe(sel, 1);
    if (st_wr) begin oct_valid = 1; oct_data = st_d; oct_viol = st_v; m_arrive(st_d, st_v); end
    flag_ok = 1;
    got = '0;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      got[i] = pcm_out;
      if (ins_flag !== e_ins || del_flag !== e_del) flag_ok = 0;
      if (i == 0) oct_valid = 0;
      if (i == 2 && md_wr) begin oct_valid = 1; oct_data = md_d; oct_viol = md_v; end
      if (i == 3 && md_wr) begin oct_valid = 0; m_arrive(md_d, md_v); end
      if (i == W - 1) set_strobe(sel, 0);
    end
    chk(got === e_word, {tag, " burst word"}, got, e_word);
    chk(flag_ok, {tag, " flags ins/del"}, {ins_flag, del_flag}, {e_ins, e_del});
    @(negedge clk);
    chk(pcm_out === 1'b1 && !ins_flag && !del_flag, {tag, " R3 R9 idle after burst"},
        {pcm_out, ins_flag, del_flag}, 3'b100);
  endtask

  task automatic plain(input bit sel, input string tag);
    burst(sel, 0, 1, 0, '0, 0, 0, '0, 0, tag);
  endtask

  // Pulse the unselected strobe: nothing must happen.
  task automatic other_pulse(input bit sel);
    bit ok = 1;
    @(negedge clk);
    ts_sel = sel;
    set_strobe(!sel, 1);
    for (int i = 0; i < W + 1; i++) begin
      @(negedge clk);
      if (pcm_out !== 1'b1 || ins_flag || del_flag) ok = 0;
      if (i == W - 1) set_strobe(!sel, 0);
    end
    chk(ok, "R2 unselected strobe ignored", pcm_out, 1);
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    logic [W-1:0] d;
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk);
    chk(pcm_out === 1'b1, "R1 reset pcm_out", pcm_out, 1);
    chk(ins_flag === 1'b0 && del_flag === 1'b0, "R1 reset flags", {ins_flag, del_flag}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(pcm_out === 1'b1, "R1 after reset idle", pcm_out, 1);

    plain(1, "R6 R1 empty repeat of ones");
    send(8'hA5, 1); plain(1, "R3 strobe A");
    send(8'h3C, 1); plain(0, "R2 strobe B");
    send(8'h81, 1); other_pulse(1); plain(1, "R2 pending kept");
    send(8'h11, 1); send(8'h22, 1); send(8'h33, 1);
    plain(0, "R5 deletion keeps newest");
    plain(0, "R6 repeat");
    send(8'h44, 1);
    burst(1, 0, 1, 0, '0, 0, 1, 8'h55, 1, "R4 mid-burst arrival");
    plain(1, "R4 next burst");
    send(8'h66, 1);
    burst(0, 0, 1, 1, 8'h77, 1, 0, '0, 0, "R10 same-cycle arrival");
    plain(0, "R10 held octet no delete");
    send(8'h0F, 1);
    burst(1, 1, 1, 0, '0, 0, 0, '0, 0, "R7 forced blank");
    plain(1, "R7 consumed then repeated");
    send(8'h5A, 0); burst(1, 0, 0, 0, '0, 0, 0, '0, 0, "R8 supervised no violation");
    send(8'h5A, 0); burst(1, 0, 1, 0, '0, 0, 0, '0, 0, "R8 supervision off");
    send(8'hC3, 1); burst(0, 0, 0, 0, '0, 0, 0, '0, 0, "R8 violation present");

    for (int k = 0; k < 40; k++) begin
      n = $urandom_range(0, 2);
      for (int j = 0; j < n; j++) begin
        d = W'($urandom);
        send(d, 1'($urandom_range(0, 3) != 0));
      end
      burst(1'($urandom), 1'($urandom_range(0, 7) == 0), 1'($urandom),
            1'($urandom_range(0, 5) == 0), W'($urandom), 1'($urandom),
            1'($urandom_range(0, 4) == 0), W'($urandom), 1'($urandom),
            "R5 R6 R8 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule